// File: doc/BRIEF.md
# Clock-Crossing Bus-to-Register Bridge

This bridge accepts single AXI4-Lite reads and writes in a CPU clock domain. It replays each one as a simple register access in a second user clock domain, which is asynchronous to the first. A write appears on the user side as a one-cycle write strobe. The strobe carries a word address, 32 bits of data and one enable per byte. A read appears as a one-cycle request with a word address. The bridge then waits, for as long as it takes, until the register side raises a read-valid strobe, and it captures the read data in that cycle.

The bridge handles all synchronization between the domains itself. A request toggle crosses from the CPU side and an acknowledge toggle crosses back, each through its own flop-chain synchronizer. The bridge also produces the AXI4-Lite responses. Only one transaction is in flight at a time, so the command registers stay unchanged while the user domain samples them. The read data is captured into a register, and that register stays unchanged until the CPU side has taken it.

Top module: `cdc_reg_bridge`

## Requirements
- R1: The user-side word address equals the AXI byte address shifted right by two. Byte-address bits 1:0 have no effect on it.
- R2: Each accepted write produces exactly one single-cycle `reg_wr_en` pulse. The pulse carries the W-channel data and strobes, where enable bit i qualifies data bits 8i+7 down to 8i.
- R3: Each accepted read produces exactly one single-cycle `reg_rd_req` pulse with the word address. The value on `reg_rd_data` in the cycle `reg_rd_valid` is high is returned on `s_rdata`.
- R4: After a read request the bridge waits any number of user cycles for `reg_rd_valid`. While no read is pending, `reg_rd_valid` has no effect: no data is captured and no response is raised.
- R5: From the acceptance of a transaction until its response handshake completes, `s_awready`, `s_wready` and `s_arready` stay low.
- R6: `s_bvalid` rises only after the matching `reg_wr_en` pulse has occurred. `s_bresp` and `s_rresp` are always OKAY (2'b00).
- R7: `s_bvalid` and `s_rvalid` stay high until their ready is sampled high. `s_rdata` is stable for that whole time.
- R8: If a complete write (AW and W both valid) and a read are offered in the same idle cycle, the write is accepted first.
- R9: A write is accepted only in a cycle where both `s_awvalid` and `s_wvalid` are high.
- R10: After reset, `s_bvalid`, `s_rvalid`, `reg_wr_en` and `reg_rd_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_clk | input | 1 | CPU-domain clock |
| cpu_rst | input | 1 | CPU-domain synchronous reset, active high |
| s_awaddr | input | ADDR_W | Write byte address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address accepted |
| s_wdata | input | DATA_W | Write data |
| s_wstrb | input | DATA_W/8 | Write byte strobes |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data accepted |
| s_bresp | output | 2 | Write response, always OKAY |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response taken |
| s_araddr | input | ADDR_W | Read byte address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address accepted |
| s_rdata | output | DATA_W | Read data |
| s_rresp | output | 2 | Read response, always OKAY |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data taken |
| usr_clk | input | 1 | User-domain clock |
| usr_rst | input | 1 | User-domain synchronous reset, active high |
| reg_addr | output | ADDR_W-2 | Register word address |
| reg_wr_en | output | 1 | One-cycle write strobe |
| reg_wr_data | output | DATA_W | Register write data |
| reg_wr_be | output | DATA_W/8 | Register write byte enables |
| reg_rd_req | output | 1 | One-cycle read request |
| reg_rd_valid | input | 1 | Read data valid from register side |
| reg_rd_data | input | DATA_W | Read data from register side |

## Verification
The hardest situation to create is a read-valid strobe that arrives when no read is pending. It is easiest to miss in the window just after a toggle has crossed but before the request pulse goes out. The bench responder can inject stray valid strobes carrying a marker value in every idle user cycle. It does this during a full write and around a read, and the read must still return the modelled register contents. A second hard case is a read left waiting hundreds of user cycles while an extra read address is held valid on the CPU side. This exercises both the unbounded wait and the blocking of new transactions while one is in flight.

// File: rtl/bridge_pkg.sv
package bridge_pkg;

  typedef enum logic [1:0] {
    C_IDLE  = 2'd0,
    C_WAIT  = 2'd1,
    C_BRESP = 2'd2,
    C_RRESP = 2'd3
  } cpu_state_t;

  typedef enum logic {
    U_IDLE   = 1'b0,
    U_RDWAIT = 1'b1
  } usr_state_t;

  localparam logic [1:0] RESP_OKAY = 2'b00;

endpackage

// File: rtl/bridge_pulse_sync.sv
module bridge_pulse_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tgl_in,
  output logic pulse_out
);

  // STAGES synchronizer flops plus one history flop for edge detection
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-1:0], tgl_in};
  end

  assign pulse_out = chain[STAGES] ^ chain[STAGES-1];

endmodule

// File: rtl/bridge_cpu_port.sv
module bridge_cpu_port
  import bridge_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   awaddr,
  input  logic                awvalid,
  output logic                awready,
  input  logic [DATA_W-1:0]   wdata,
  input  logic [DATA_W/8-1:0] wstrb,
  input  logic                wvalid,
  output logic                wready,
  output logic [1:0]          bresp,
  output logic                bvalid,
  input  logic                bready,
  input  logic [ADDR_W-1:0]   araddr,
  input  logic                arvalid,
  output logic                arready,
  output logic [DATA_W-1:0]   rdata,
  output logic [1:0]          rresp,
  output logic                rvalid,
  input  logic                rready,
  output logic                cmd_wr,
  output logic [ADDR_W-3:0]   cmd_addr,
  output logic [DATA_W-1:0]   cmd_data,
  output logic [DATA_W/8-1:0] cmd_strb,
  output logic                req_tgl,
  input  logic                ack_pulse,
  input  logic [DATA_W-1:0]   rd_hold
);

  cpu_state_t state;
  logic       wr_go;
  logic       rd_go;
  logic       unused_lsb;

  assign unused_lsb = ^{awaddr[1:0], araddr[1:0]};

  // write wins over a read offered in the same idle cycle
  assign wr_go   = (state == C_IDLE) && awvalid && wvalid;
  assign rd_go   = (state == C_IDLE) && arvalid && !(awvalid && wvalid);
  assign awready = wr_go;
  assign wready  = wr_go;
  assign arready = rd_go;
  assign bresp   = RESP_OKAY;
  assign rresp   = RESP_OKAY;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= C_IDLE;
      cmd_wr   <= 1'b0;
      cmd_addr <= '0;
      cmd_data <= '0;
      cmd_strb <= '0;
      req_tgl  <= 1'b0;
      bvalid   <= 1'b0;
      rvalid   <= 1'b0;
      rdata    <= '0;
    end else begin
      unique case (state)
        C_IDLE: begin
          if (wr_go) begin
            cmd_wr   <= 1'b1;
            cmd_addr <= awaddr[ADDR_W-1:2];
            cmd_data <= wdata;
            cmd_strb <= wstrb;
            req_tgl  <= ~req_tgl;
            state    <= C_WAIT;
          end else if (rd_go) begin
            cmd_wr   <= 1'b0;
            cmd_addr <= araddr[ADDR_W-1:2];
            req_tgl  <= ~req_tgl;
            state    <= C_WAIT;
          end
        end
        C_WAIT: begin
          if (ack_pulse) begin
            if (cmd_wr) begin
              bvalid <= 1'b1;
              state  <= C_BRESP;
            end else begin
              rvalid <= 1'b1;
              rdata  <= rd_hold;
              state  <= C_RRESP;
            end
          end
        end
        C_BRESP: begin
          if (bready) begin
            bvalid <= 1'b0;
            state  <= C_IDLE;
          end
        end
        C_RRESP: begin
          if (rready) begin
            rvalid <= 1'b0;
            state  <= C_IDLE;
          end
        end
        default: state <= C_IDLE;
      endcase
    end
  end

  AST_BVALID_HOLD: assert property (@(posedge clk) disable iff (rst)
    (bvalid && !bready) |=> bvalid); // R7
  AST_RDATA_STABLE: assert property (@(posedge clk) disable iff (rst)
    (rvalid && !rready) |=> (rvalid && $stable(rdata))); // R7
  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
    (bvalid || rvalid) |-> !(awready || wready || arready)); // R5
  AST_ACK_ONLY_WAIT: assert property (@(posedge clk) disable iff (rst)
    ack_pulse |-> (state == C_WAIT)); // R4

endmodule

// File: rtl/bridge_user_port.sv
module bridge_user_port
  import bridge_pkg::*;
#(
  parameter int WADDR_W = 10,
  parameter int DATA_W  = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_pulse,
  input  logic                cmd_wr,
  input  logic [WADDR_W-1:0]  cmd_addr,
  input  logic [DATA_W-1:0]   cmd_data,
  input  logic [DATA_W/8-1:0] cmd_strb,
  output logic [WADDR_W-1:0]  reg_addr,
  output logic                reg_wr_en,
  output logic [DATA_W-1:0]   reg_wr_data,
  output logic [DATA_W/8-1:0] reg_wr_be,
  output logic                reg_rd_req,
  input  logic                reg_rd_valid,
  input  logic [DATA_W-1:0]   reg_rd_data,
  output logic [DATA_W-1:0]   rd_hold,
  output logic                ack_tgl
);

  usr_state_t state;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= U_IDLE;
      reg_addr    <= '0;
      reg_wr_en   <= 1'b0;
      reg_wr_data <= '0;
      reg_wr_be   <= '0;
      reg_rd_req  <= 1'b0;
      rd_hold     <= '0;
      ack_tgl     <= 1'b0;
    end else begin
      reg_wr_en  <= 1'b0;
      reg_rd_req <= 1'b0;
      unique case (state)
        U_IDLE: begin
          if (req_pulse) begin
            reg_addr <= cmd_addr;
            if (cmd_wr) begin
              reg_wr_en   <= 1'b1;
              reg_wr_data <= cmd_data;
              reg_wr_be   <= cmd_strb;
              ack_tgl     <= ~ack_tgl;
            end else begin
              reg_rd_req <= 1'b1;
              state      <= U_RDWAIT;
            end
          end
        end
        U_RDWAIT: begin
          if (reg_rd_valid) begin
            rd_hold <= reg_rd_data;
            ack_tgl <= ~ack_tgl;
            state   <= U_IDLE;
          end
        end
        default: state <= U_IDLE;
      endcase
    end
  end

  AST_WR_SINGLE: assert property (@(posedge clk) disable iff (rst)
    reg_wr_en |=> !reg_wr_en); // R2
  AST_RD_SINGLE: assert property (@(posedge clk) disable iff (rst)
    reg_rd_req |=> !reg_rd_req); // R3
  AST_REQ_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    req_pulse |-> (state == U_IDLE)); // R5
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (state == U_IDLE && !req_pulse) |=> $stable(rd_hold)); // R4

endmodule

// File: rtl/cdc_reg_bridge.sv
module cdc_reg_bridge #(
  parameter int ADDR_W      = 12,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                cpu_clk,
  input  logic                cpu_rst,
  input  logic [ADDR_W-1:0]   s_awaddr,
  input  logic                s_awvalid,
  output logic                s_awready,
  input  logic [DATA_W-1:0]   s_wdata,
  input  logic [DATA_W/8-1:0] s_wstrb,
  input  logic                s_wvalid,
  output logic                s_wready,
  output logic [1:0]          s_bresp,
  output logic                s_bvalid,
  input  logic                s_bready,
  input  logic [ADDR_W-1:0]   s_araddr,
  input  logic                s_arvalid,
  output logic                s_arready,
  output logic [DATA_W-1:0]   s_rdata,
  output logic [1:0]          s_rresp,
  output logic                s_rvalid,
  input  logic                s_rready,
  input  logic                usr_clk,
  input  logic                usr_rst,
  output logic [ADDR_W-3:0]   reg_addr,
  output logic                reg_wr_en,
  output logic [DATA_W-1:0]   reg_wr_data,
  output logic [DATA_W/8-1:0] reg_wr_be,
  output logic                reg_rd_req,
  input  logic                reg_rd_valid,
  input  logic [DATA_W-1:0]   reg_rd_data
);

  localparam int WADDR_W = ADDR_W - 2;
  localparam int STRB_W  = DATA_W / 8;

  logic               cmd_wr;
  logic [WADDR_W-1:0] cmd_addr;
  logic [DATA_W-1:0]  cmd_data;
  logic [STRB_W-1:0]  cmd_strb;
  logic               req_tgl;
  logic               req_pulse;
  logic               ack_tgl;
  logic               ack_pulse;
  logic [DATA_W-1:0]  rd_hold;

  bridge_cpu_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cpu (
    .clk(cpu_clk), .rst(cpu_rst),
    .awaddr(s_awaddr), .awvalid(s_awvalid), .awready(s_awready),
    .wdata(s_wdata), .wstrb(s_wstrb), .wvalid(s_wvalid), .wready(s_wready),
    .bresp(s_bresp), .bvalid(s_bvalid), .bready(s_bready),
    .araddr(s_araddr), .arvalid(s_arvalid), .arready(s_arready),
    .rdata(s_rdata), .rresp(s_rresp), .rvalid(s_rvalid), .rready(s_rready),
    .cmd_wr(cmd_wr), .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cmd_strb(cmd_strb),
    .req_tgl(req_tgl), .ack_pulse(ack_pulse), .rd_hold(rd_hold)
  );

  bridge_pulse_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk(usr_clk), .rst(usr_rst), .tgl_in(req_tgl), .pulse_out(req_pulse)
  );

  bridge_pulse_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk(cpu_clk), .rst(cpu_rst), .tgl_in(ack_tgl), .pulse_out(ack_pulse)
  );

  bridge_user_port #(.WADDR_W(WADDR_W), .DATA_W(DATA_W)) u_usr (
    .clk(usr_clk), .rst(usr_rst), .req_pulse(req_pulse),
    .cmd_wr(cmd_wr), .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cmd_strb(cmd_strb),
    .reg_addr(reg_addr), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
    .reg_wr_be(reg_wr_be), .reg_rd_req(reg_rd_req), .reg_rd_valid(reg_rd_valid),
    .reg_rd_data(reg_rd_data), .rd_hold(rd_hold), .ack_tgl(ack_tgl)
  );

  AST_OUT_EXCLUSIVE: assert property (@(posedge usr_clk) disable iff (usr_rst)
    !(reg_wr_en && reg_rd_req)); // R5
  AST_RESP_EXCLUSIVE: assert property (@(posedge cpu_clk) disable iff (cpu_rst)
    !(s_bvalid && s_rvalid)); // R5

endmodule

// File: tb/cdc_reg_bridge_test.sv
module cdc_reg_bridge_test;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int WADDR_W = ADDR_W - 2;
  localparam int DEPTH = 1 << WADDR_W;

  logic cpu_clk = 0, usr_clk = 0, cpu_rst = 1, usr_rst = 1;
  always #10 cpu_clk = ~cpu_clk;
  always #7  usr_clk = ~usr_clk;

  logic [ADDR_W-1:0] s_awaddr = '0, s_araddr = '0;
  logic s_awvalid = 0, s_wvalid = 0, s_bready = 0, s_arvalid = 0, s_rready = 0;
  logic [DATA_W-1:0] s_wdata = '0;
  logic [3:0] s_wstrb = '0;
  logic s_awready, s_wready, s_bvalid, s_arready, s_rvalid;
  logic [1:0] s_bresp, s_rresp;
  logic [DATA_W-1:0] s_rdata;
  logic [WADDR_W-1:0] reg_addr;
  logic reg_wr_en, reg_rd_req;
  logic [DATA_W-1:0] reg_wr_data;
  logic [3:0] reg_wr_be;
  logic reg_rd_valid = 0;
  logic [DATA_W-1:0] reg_rd_data = '0;

  cdc_reg_bridge uut (.*);

  int checks = 0, errors = 0;
  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  typedef struct { bit wr; logic [WADDR_W-1:0] a; logic [31:0] d; logic [3:0] be; } ev_t;
  ev_t evq[$];
  logic [31:0] umem [DEPTH];
  logic [31:0] emem [DEPTH];
  int rd_lat = 0, wr_issued = 0, wr_seen = 0;
  bit spur = 0, busy = 0;

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] d,
                                        input logic [3:0] be);
    logic [31:0] r = old;
    for (int i = 0; i < 4; i++) if (be[i]) r[8*i +: 8] = d[8*i +: 8];
    return r;
  endfunction

  // behavioural register-side responder and event model
  bit pend = 0, pwe = 0, prr = 0;
  int cnt = 0;
  logic [WADDR_W-1:0] ra;
  always @(negedge usr_clk) begin
    ev_t e;
    reg_rd_valid = 0;
    if (!usr_rst) begin
      if (reg_wr_en) begin
        chk(!pwe, "R2", "write strobe longer than one cycle", 1, 0);
        if (evq.size() == 0) chk(0, "R2", "unexpected write strobe", 1, 0);
        else begin
          e = evq.pop_front();
          chk(e.wr, "R2", "write where read expected", 0, 1);
          chk(reg_addr == e.a, "R1", "write word address", 32'(reg_addr), 32'(e.a));
          chk(reg_wr_data == e.d, "R2", "write data", reg_wr_data, e.d);
          chk(reg_wr_be == e.be, "R2", "byte enables", 32'(reg_wr_be), 32'(e.be));
          umem[reg_addr] = merge(umem[reg_addr], reg_wr_data, reg_wr_be);
          wr_seen++;
        end
      end
      if (reg_rd_req) begin
        chk(!prr, "R3", "read request longer than one cycle", 1, 0);
        if (evq.size() == 0) chk(0, "R3", "unexpected read request", 1, 0);
        else begin
          e = evq.pop_front();
          chk(!e.wr, "R3", "read where write expected", 1, 0);
          chk(reg_addr == e.a, "R1", "read word address", 32'(reg_addr), 32'(e.a));
        end
        pend = 1; cnt = rd_lat; ra = reg_addr;
      end
      if (pend) begin
        if (cnt == 0) begin
          reg_rd_valid = 1; reg_rd_data = umem[ra]; pend = 0;
        end else cnt--;
      end else if (spur) begin
        reg_rd_valid = 1; reg_rd_data = 32'hDEADBEEF;
      end
    end
    pwe = reg_wr_en; prr = reg_rd_req;
  end

  // CPU-side per-cycle protocol model
  bit pbv = 0, pbr = 0, prv = 0, prr2 = 0;
  logic [31:0] prd = '0;
  always @(negedge cpu_clk) begin
    #2;
    if (!cpu_rst) begin
      if (busy) chk(!(s_awready || s_wready || s_arready), "R5", "ready while busy",
                    {s_awready, s_wready, s_arready}, 0);
      if (pbv && !pbr) chk(s_bvalid, "R7", "bvalid dropped before bready", s_bvalid, 1);
      if (prv && !prr2) begin
        chk(s_rvalid, "R7", "rvalid dropped before rready", s_rvalid, 1);
        chk(s_rdata == prd, "R7", "rdata changed while waiting", s_rdata, prd);
      end
      if (s_bvalid && !pbv) begin
        chk(wr_seen == wr_issued, "R6", "bvalid before write strobe", wr_seen, wr_issued);
        chk(s_bresp == 2'b00, "R6", "bresp", s_bresp, 0);
      end
      if (s_rvalid && !prv) chk(s_rresp == 2'b00, "R6", "rresp", s_rresp, 0);
    end
    pbv = s_bvalid; pbr = s_bready; prv = s_rvalid; prr2 = s_rready; prd = s_rdata;
  end

  task automatic expect_wr(input logic [ADDR_W-1:0] a, input logic [31:0] d, input logic [3:0] be);
    evq.push_back('{1'b1, a[ADDR_W-1:2], d, be});
    emem[a[ADDR_W-1:2]] = merge(emem[a[ADDR_W-1:2]], d, be);
  endtask

  task automatic finish_b(input int dly);
    while (!s_bvalid) @(negedge cpu_clk);
    repeat (dly) @(negedge cpu_clk);
    s_bready = 1;
    @(negedge cpu_clk);
    s_bready = 0; busy = 0;
  endtask

  task automatic finish_r(input logic [WADDR_W-1:0] wa, input int dly, input string req);
    while (!s_rvalid) @(negedge cpu_clk);
    repeat (dly) @(negedge cpu_clk);
    chk(s_rdata == emem[wa], req, "read data", s_rdata, emem[wa]);
    s_rready = 1;
    @(negedge cpu_clk);
    s_rready = 0; busy = 0;
  endtask

  task automatic axi_wr(input logic [ADDR_W-1:0] a, input logic [31:0] d,
                        input logic [3:0] be, input int dly);
    expect_wr(a, d, be);
    @(negedge cpu_clk);
    s_awaddr = a; s_wdata = d; s_wstrb = be; s_awvalid = 1; s_wvalid = 1;
    #1;
    while (!(s_awready && s_wready)) begin @(negedge cpu_clk); #1; end
    @(negedge cpu_clk);
    s_awvalid = 0; s_wvalid = 0; busy = 1; wr_issued++;
    finish_b(dly);
  endtask

  task automatic axi_rd(input logic [ADDR_W-1:0] a, input int dly, input string req);
    evq.push_back('{1'b0, a[ADDR_W-1:2], 32'h0, 4'h0});
    @(negedge cpu_clk);
    s_araddr = a; s_arvalid = 1;
    #1;
    while (!s_arready) begin @(negedge cpu_clk); #1; end
    @(negedge cpu_clk);
    s_arvalid = 0; busy = 1;
    finish_r(a[ADDR_W-1:2], dly, req);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) begin umem[i] = i * 32'h01010101; emem[i] = umem[i]; end
    repeat (8) @(negedge cpu_clk);
    cpu_rst = 0; usr_rst = 0;
    @(negedge cpu_clk); #1;
    // R10 reset state
    chk(!s_bvalid && !s_rvalid, "R10", "response valids after reset", {s_bvalid, s_rvalid}, 0);
    chk(!reg_wr_en && !reg_rd_req, "R10", "user strobes after reset", {reg_wr_en, reg_rd_req}, 0);

    // R2 full write and readback; R3
    axi_wr(12'h010, 32'hA5A5_1234, 4'hF, 0);
    axi_rd(12'h010, 0, "R3");
    // R2 partial byte enables, delayed bready (R7)
    axi_wr(12'h010, 32'h7766_5544, 4'b0101, 5);
    axi_rd(12'h010, 4, "R2");
    axi_wr(12'h020, 32'hCAFE_F00D, 4'b1000, 0);
    axi_rd(12'h020, 0, "R2");
    // R1 low address bits ignored
    axi_wr(12'h0A7, 32'h1357_9BDF, 4'hF, 0);
    axi_rd(12'h0A5, 2, "R1");
    axi_rd(12'hFFE, 0, "R1");

    // R9 address alone is not accepted
    @(negedge cpu_clk);
    s_awaddr = 12'h044; s_awvalid = 1; s_wdata = 32'h0BAD_0BAD; s_wstrb = 4'hF;
    for (int i = 0; i < 5; i++) begin
      #1; chk(!s_awready && !s_wready, "R9", "accepted without W", {s_awready, s_wready}, 0);
      @(negedge cpu_clk);
    end
    expect_wr(12'h044, 32'h0BAD_0BAD, 4'hF);
    s_wvalid = 1; #1;
    chk(s_awready && s_wready, "R9", "accept when both valid", {s_awready, s_wready}, 3);
    @(negedge cpu_clk); s_awvalid = 0; s_wvalid = 0; busy = 1; wr_issued++;
    finish_b(0);

    // R8 write before read; R5 read held off meanwhile
    @(negedge cpu_clk);
    expect_wr(12'h100, 32'h2468_ACE0, 4'hF);
    evq.push_back('{1'b0, 10'h040, 32'h0, 4'h0});
    s_awaddr = 12'h100; s_wdata = 32'h2468_ACE0; s_wstrb = 4'hF;
    s_awvalid = 1; s_wvalid = 1; s_araddr = 12'h100; s_arvalid = 1;
    #1;
    chk(s_awready && !s_arready, "R8", "write priority", {s_awready, s_arready}, 2);
    @(negedge cpu_clk); s_awvalid = 0; s_wvalid = 0; busy = 1; wr_issued++;
    finish_b(3);
    #1; while (!s_arready) begin @(negedge cpu_clk); #1; end
    @(negedge cpu_clk); s_arvalid = 0; busy = 1;
    finish_r(10'h040, 0, "R8");

    // R4 long wait for read-valid and stray valids when idle
    spur = 1;
    repeat (20) @(negedge cpu_clk);
    chk(!s_bvalid && !s_rvalid, "R4", "stray read-valid raised response", {s_bvalid, s_rvalid}, 0);
    axi_wr(12'h200, 32'h5555_AAAA, 4'hF, 0);
    rd_lat = 400;
    axi_rd(12'h200, 0, "R4");
    rd_lat = 0;
    axi_rd(12'h010, 1, "R4");
    spur = 0;

    repeat (10) @(negedge cpu_clk);
    chk(evq.size() == 0, "R3", "missing user-side strobes", evq.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge cpu_clk);
    errors++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule